// File: doc/BRIEF.md
# Software-Priority Interrupt Controller

This block arbitrates a set of peripheral interrupt lines, a top-level hardware interrupt and a software trap for a processor core. Each peripheral vector has a 2-bit software priority, and a numerically larger value wins. The controller keeps the core's current execution level. An interrupt is granted only when its priority is strictly above that level. When a vector is granted, its priority becomes the new current level, and the previous level goes onto a small save stack. A handler-return pulse restores the previous level from that stack.

Two arbitration modes can be selected. In nested mode, a strictly higher-priority request preempts a running handler. In concurrent mode, no maskable request is granted while any handler is active. The trap and the top-level interrupt do not depend on levels or masks. They outrank every peripheral and raise the current level to 3. A small register window lets software set the per-vector priorities and the mode, and write the current level. After reset, every priority field and the current level are 3, so peripherals stay blocked until software lowers the level.

Top module: `irq_swprio_ctrl`

## Requirements
- R1: After reset, `take_o` is 0, `lvl_o` is 3, every priority field reads 3, the mode bit reads 0 (nested), and asserted peripheral requests are not granted.
- R2: Register window, with `cfg_addr_i` from 0 to N_VEC-1 selecting that vector's 2-bit priority, N_VEC the mode bit (bit 0, 1 = concurrent), and N_VEC+1 the current level. A write takes effect at the clock edge, and `cfg_rdata_o` returns the addressed value combinationally.
- R3: A peripheral request is granted only if its line and its enable are both 1 and its priority is strictly greater than the current level. A request whose enable is 0 is never granted.
- R4: Among eligible peripherals, the highest priority wins. On equal priority, the lowest index wins.
- R5: A grant shows one clock edge after the request is sampled. `take_o` is 1 for that cycle, `vec_o` is 2+index for peripheral index, and `lvl_o` equals the granted priority.
- R6: In nested mode (mode 0), a running handler is preempted by a request of strictly higher priority only. An equal priority does not preempt.
- R7: In concurrent mode (mode 1), no peripheral request is granted while at least one handler level is saved.
- R8: The trap (`vec_o` 0) outranks the top-level interrupt (`vec_o` 1), which outranks all peripherals, regardless of level and mode. Either one sets the level to 3. While a trap or top-level handler is current, nothing else is granted.
- R9: A return pulse restores the most recently saved level at the next edge. A return with nothing saved leaves the level unchanged, and no grant happens in a cycle with a return.
- R10: At most 3 levels are saved. While 3 are saved, no request of any kind is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_VEC | Peripheral request lines |
| irq_en_i | input | N_VEC | Per-vector enable |
| tli_i | input | 1 | Top-level hardware interrupt |
| trap_i | input | 1 | Software trap request |
| ret_i | input | 1 | Handler return pulse |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | $clog2(N_VEC+2) | Register address |
| cfg_wdata_i | input | 2 | Register write data |
| cfg_rdata_o | output | 2 | Register read data |
| take_o | output | 1 | Grant pulse |
| vec_o | output | $clog2(N_VEC+2) | Granted vector code |
| lvl_o | output | 2 | Current execution level |

## Verification
Grants, level changes from returns, and register writes all appear one clock edge after the inputs are presented. Register reads are combinational and are valid in the same cycle. The bench applies each stimulus on a falling edge and holds it across exactly one rising edge. It then removes the stimulus and reads the outputs at the following falling edge. The sweeps cover every pairing of priority and current level, and two-vector contention at all priority pairs. Each grant is undone with a return, so every case starts from an empty save stack.

// File: rtl/irq_swprio_pkg.sv
package irq_swprio_pkg;
  typedef logic [1:0] lvl_t;
  typedef struct packed {
    logic nm;
    lvl_t lvl;
  } ctx_t;
  localparam lvl_t LVL_MAX  = 2'd3;
  localparam int   VEC_TRAP = 0;
  localparam int   VEC_TLI  = 1;
  localparam int   VEC_BASE = 2;
endpackage

// File: rtl/irq_swprio_arb.sv
module irq_swprio_arb
  import irq_swprio_pkg::*;
#(
  parameter int N_VEC = 8,
  localparam int IW = $clog2(N_VEC)
) (
  input  logic [N_VEC-1:0]      pend_i,
  input  logic [N_VEC-1:0][1:0] prio_i,
  output logic                  any_o,
  output logic [IW-1:0]         idx_o,
  output lvl_t                  prio_o
);
  // downward scan with >= leaves the lowest index on ties
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (pend_i[i] && (!any_o || prio_i[i] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IW'(i);
        prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_swprio_lvl_stack.sv
module irq_swprio_lvl_stack
  import irq_swprio_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  ctx_t          push_ctx_i,
  output ctx_t          top_o,
  output logic [DW-1:0] depth_o,
  output logic          full_o,
  output logic          empty_o
);
  ctx_t          mem_q [DEPTH];
  logic [DW-1:0] depth_q;

  assign full_o  = (depth_q == DW'(DEPTH));
  assign empty_o = (depth_q == '0);
  assign depth_o = depth_q;
  assign top_o   = empty_o ? '0 : mem_q[depth_q - 1'b1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[depth_q] <= push_ctx_i;
      depth_q        <= depth_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      depth_q <= depth_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_swprio_cfg.sv
module irq_swprio_cfg
  import irq_swprio_pkg::*;
#(
  parameter int N_VEC = 8,
  localparam int AW = $clog2(N_VEC + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  lvl_t                  wdata_i,
  input  lvl_t                  cur_lvl_i,
  output lvl_t                  rdata_o,
  output logic [N_VEC-1:0][1:0] prio_o,
  output logic                  mode_o,
  output logic                  lvl_we_o
);
  logic [N_VEC-1:0][1:0] prio_q;
  logic                  mode_q;

  assign prio_o   = prio_q;
  assign mode_o   = mode_q;
  assign lvl_we_o = we_i && (addr_i == AW'(N_VEC + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_VEC; i++) prio_q[i] <= LVL_MAX;
      mode_q <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < N_VEC; i++)
        if (addr_i == AW'(i)) prio_q[i] <= wdata_i;
      if (addr_i == AW'(N_VEC)) mode_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_VEC; i++)
      if (addr_i == AW'(i)) rdata_o = prio_q[i];
    if (addr_i == AW'(N_VEC))     rdata_o = {1'b0, mode_q};
    if (addr_i == AW'(N_VEC + 1)) rdata_o = cur_lvl_i;
  end
endmodule

// File: rtl/irq_swprio_ctrl.sv
module irq_swprio_ctrl
  import irq_swprio_pkg::*;
#(
  parameter int N_VEC      = 8,
  parameter int SAVE_DEPTH = 3,
  localparam int AW = $clog2(N_VEC + 2),
  localparam int VW = AW,
  localparam int IW = $clog2(N_VEC),
  localparam int DW = $clog2(SAVE_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_VEC-1:0] irq_req_i,
  input  logic [N_VEC-1:0] irq_en_i,
  input  logic             tli_i,
  input  logic             trap_i,
  input  logic             ret_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [1:0]       cfg_wdata_i,
  output logic [1:0]       cfg_rdata_o,
  output logic             take_o,
  output logic [VW-1:0]    vec_o,
  output logic [1:0]       lvl_o
);
  logic [N_VEC-1:0][1:0] prio;
  logic                  mode_q, lvl_we;
  logic                  m_any;
  logic [IW-1:0]         m_idx;
  lvl_t                  m_prio;
  lvl_t                  cur_lvl_q;
  logic                  cur_nm_q;
  ctx_t                  top_ctx;
  lvl_t                  top_lvl;
  logic [DW-1:0]         depth;
  logic                  full, empty;
  logic                  nm_req, can_take, nm_take, m_take, take, pop;
  logic [VW-1:0]         new_vec;
  lvl_t                  new_lvl;
  logic                  take_q;
  logic [VW-1:0]         vec_q;

  irq_swprio_cfg #(.N_VEC(N_VEC)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .cur_lvl_i (cur_lvl_q),
    .rdata_o   (cfg_rdata_o),
    .prio_o    (prio),
    .mode_o    (mode_q),
    .lvl_we_o  (lvl_we)
  );

  irq_swprio_arb #(.N_VEC(N_VEC)) u_arb (
    .pend_i (irq_req_i & irq_en_i),
    .prio_i (prio),
    .any_o  (m_any),
    .idx_o  (m_idx),
    .prio_o (m_prio)
  );

  irq_swprio_lvl_stack #(.DEPTH(SAVE_DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .pop_i      (pop),
    .push_ctx_i ('{nm: cur_nm_q, lvl: cur_lvl_q}),
    .top_o      (top_ctx),
    .depth_o    (depth),
    .full_o     (full),
    .empty_o    (empty)
  );

  assign top_lvl  = top_ctx.lvl;
  assign nm_req   = trap_i || tli_i;
  assign can_take = !ret_i && !full && !cur_nm_q;
  assign nm_take  = nm_req && can_take;
  // concurrent mode: maskable only from base context
  assign m_take   = !nm_req && m_any && can_take && (m_prio > cur_lvl_q)
                    && !(mode_q && !empty);
  assign take     = nm_take || m_take;
  assign pop      = ret_i && !empty;

  always_comb begin
    if (trap_i)     new_vec = VW'(VEC_TRAP);
    else if (tli_i) new_vec = VW'(VEC_TLI);
    else            new_vec = VW'(m_idx) + VW'(VEC_BASE);
    new_lvl = nm_take ? LVL_MAX : m_prio;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_lvl_q <= LVL_MAX;
      cur_nm_q  <= 1'b0;
      take_q    <= 1'b0;
      vec_q     <= '0;
    end else begin
      take_q <= take;
      if (take) begin
        vec_q     <= new_vec;
        cur_lvl_q <= new_lvl;
        cur_nm_q  <= nm_take;
      end else if (pop) begin
        cur_lvl_q <= top_ctx.lvl;
        cur_nm_q  <= top_ctx.nm;
      end else if (lvl_we) begin
        cur_lvl_q <= cfg_wdata_i;
      end
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign lvl_o  = cur_lvl_q;
endmodule

// File: rtl/irq_swprio_chk.sv
module irq_swprio_chk #(
  parameter int VW   = 4,
  parameter int DW   = 2,
  parameter int FULL = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          take_i,
  input logic [VW-1:0] vec_i,
  input logic [1:0]    lvl_i,
  input logic          ret_i,
  input logic [DW-1:0] depth_i,
  input logic [1:0]    top_lvl_i,
  input logic          mode_i
);
  p_nm_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (vec_i < VW'(2)) |-> lvl_i == 2'd3);

  p_full_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == DW'(FULL)) |=> !take_i);

  p_ret_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && (depth_i != '0) |=> lvl_i == $past(top_lvl_i));

  p_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (vec_i >= VW'(2)) |-> lvl_i > $past(lvl_i));

  p_conc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (vec_i >= VW'(2)) && $past(mode_i) |-> $past(depth_i) == '0);
endmodule

bind irq_swprio_ctrl irq_swprio_chk #(.VW(VW), .DW(DW), .FULL(SAVE_DEPTH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .take_i    (take_o),
  .vec_i     (vec_o),
  .lvl_i     (lvl_o),
  .ret_i     (ret_i),
  .depth_i   (depth),
  .top_lvl_i (top_lvl),
  .mode_i    (mode_q)
);

// File: tb/irq_swprio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_swprio_ctrl_tb_top;
  localparam int N  = 8;
  localparam int AW = $clog2(N + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0, irq_en = '1;
  logic          tli = 1'b0, trap = 1'b0, ret = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    wdata = '0, rdata, lvl_o;
  logic          take_o;
  logic [AW-1:0] vec_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_swprio_ctrl #(.N_VEC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .tli_i(tli), .trap_i(trap), .ret_i(ret), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .take_o(take_o), .vec_o(vec_o), .lvl_o(lvl_o)
  );

  task automatic chk(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic fire(logic [N-1:0] rq, logic tl, logic tr, logic rt);
    irq_req = rq; tli = tl; trap = tr; ret = rt;
    @(posedge clk); @(negedge clk);
    irq_req = '0; tli = 1'b0; trap = 1'b0; ret = 1'b0;
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = AW'(a); wdata = 2'(d);
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(string r, int a, int exp);
    addr = AW'(a); #1;
    chk(r, int'(rdata), exp);
  endtask

  task automatic obs(string r, int tk, int vec, int lvl);
    chk({r, " take"}, int'(take_o), tk);
    if (tk != 0) chk({r, " vec"}, int'(vec_o), vec);
    chk({r, " level"}, int'(lvl_o), lvl);
  endtask

  task automatic unwind(string r, int lvl);
    fire('0, 1'b0, 1'b0, 1'b1);
    chk({r, " restore"}, int'(lvl_o), lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 take", int'(take_o), 0);
    chk("R1 level", int'(lvl_o), 3);
    for (int i = 0; i < N; i++) rd("R1 prio", i, 3);
    rd("R1 mode", N, 0);
    fire('1, 1'b0, 1'b0, 1'b0);
    obs("R1 blocked", 0, 0, 3);

    // R3 level gating and enable gating, vector 3
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 4; p++)
        for (int e = 0; e < 2; e++) begin
          wr(3, p); wr(N + 1, c);
          rd("R2 level", N + 1, c);
          irq_en = (e == 1) ? 8'hFF : 8'hF7;
          fire(8'h08, 1'b0, 1'b0, 1'b0);
          obs("R3", (e == 1 && p > c) ? 1 : 0, 5, (e == 1 && p > c) ? p : c);
          if (e == 1 && p > c) unwind("R9", c);
        end
    irq_en = '1;

    // R4 two-way contention, vectors 1 and 6
    for (int i = 0; i < N; i++) wr(i, 0);
    wr(N + 1, 0);
    for (int pa = 0; pa < 4; pa++)
      for (int pb = 0; pb < 4; pb++) begin
        wr(1, pa); wr(6, pb);
        rd("R2 prio", 6, pb);
        fire(8'h42, 1'b0, 1'b0, 1'b0);
        obs("R4", (pa > 0 || pb > 0) ? 1 : 0, (pa >= pb) ? 3 : 8,
            (pa >= pb) ? pa : pb);
        if (pa > 0 || pb > 0) unwind("R9", 0);
      end
    for (int i = 0; i < N; i++) wr(i, 2);
    fire('1, 1'b0, 1'b0, 1'b0);
    obs("R4 tie", 1, 2, 2);
    unwind("R9", 0);

    // R5 R6 R10 nesting
    wr(0, 1); wr(1, 2); wr(2, 3);
    fire(8'h01, 1'b0, 1'b0, 1'b0); obs("R5", 1, 2, 1);
    fire(8'h03, 1'b0, 1'b0, 1'b0); obs("R6 higher", 1, 3, 2);
    fire(8'h02, 1'b0, 1'b0, 1'b0); obs("R6 equal", 0, 0, 2);
    fire(8'h04, 1'b0, 1'b0, 1'b0); obs("R6 top", 1, 4, 3);
    fire(8'h00, 1'b0, 1'b1, 1'b0); obs("R10 full", 0, 0, 3);
    unwind("R9", 2); unwind("R9", 1); unwind("R9", 0); unwind("R9 empty", 0);

    // R7 concurrent mode
    wr(N, 1); rd("R2 mode", N, 1);
    fire(8'h01, 1'b0, 1'b0, 1'b0); obs("R7 first", 1, 2, 1);
    fire(8'h04, 1'b0, 1'b0, 1'b0); obs("R7 hold", 0, 0, 1);
    unwind("R9", 0);
    fire(8'h04, 1'b0, 1'b0, 1'b0); obs("R7 idle", 1, 4, 3);
    unwind("R9", 0);
    wr(N, 0);

    // R8 non-maskable
    fire(8'h04, 1'b1, 1'b1, 1'b0); obs("R8 trap", 1, 0, 3);
    fire(8'h00, 1'b1, 1'b0, 1'b0); obs("R8 busy", 0, 0, 3);
    unwind("R9", 0);
    fire(8'h04, 1'b1, 1'b0, 1'b0); obs("R8 tli", 1, 1, 3);
    unwind("R9", 0);
    wr(N + 1, 3);
    fire(8'h00, 1'b0, 1'b1, 1'b0); obs("R8 at3", 1, 0, 3);
    unwind("R9", 3);

    // R9 return blocks a grant
    wr(N + 1, 0);
    fire(8'h04, 1'b0, 1'b0, 1'b1); obs("R9 ret", 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule